// File: doc/BRIEF.md
# Protected Data EEPROM Controller

This block fronts a 1024-byte nonvolatile data store with a small register bus. Software points at a byte through a split low/high address register pair, moves bytes through a data register, and drives operations from a control register. A read strobe copies the addressed byte into the data register at once. A write takes longer and needs an armed unlock handshake on a dedicated write-only register. The programming interval then runs for a fixed number of clocks.

The write path is guarded against runaway code in three ways. A persistent write-enable bit must already be set. Two exact unlock bytes must arrive in order, with no other register access between them. The arming is then spent by the very next control write. While a byte is being programmed, the address, data and control registers refuse bus writes, so the target cannot shift under the cycle. Completion raises a sticky flag that only software can clear. The flag can also drive an interrupt output.

Top module: `nvm_data_ctrl`

## Requirements
- R1: Register offsets on `bus_off_i` are 0 address low byte, 1 address high bits (bits 1:0), 2 data, 3 control, 4 unlock. After reset every register reads 0 and `busy_o` and `irq_o` are low.
- R2: Control bits: 0 read strobe, 1 write strobe/busy, 2 write enable, 4 done flag, 5 interrupt enable, 6 and 7 space selects (both must be 0 for data memory). A control write with bit 0 set and bits 7:6 clear loads the data register from the array at the current address, and the value is readable in the next cycle. Bit 0 reads back 0. With either select bit set, the data register is not loaded.
- R3: The data register holds its value until the next read strobe or a bus write to offset 2.
- R4: A write starts only when 55h and then AAh are written to offset 4, followed by a control write with bit 1 set. A wrong byte, a swapped order, or any access to another offset between the two bytes returns the handshake to idle. The armed state is consumed by the next control write.
- R5: Every byte needs a fresh handshake. A second control write with bit 1 set and no new handshake starts nothing.
- R6: The write enable bit must already be 1 before the arming control write. A control write that sets bits 1 and 2 together does not start a write.
- R7: Hardware never clears the write enable bit.
- R8: While a write runs, bus writes to offsets 0 to 3 are ignored, and so are unlock bytes.
- R9: A write holds `busy_o` and control bit 1 high for exactly `WR_CYCLES` clocks after the starting edge. The array takes the byte at the end of that interval.
- R10: On completion, control bit 1 clears and bit 4 sets. `irq_o` is high while bits 4 and 5 are both set.
- R11: Bit 4 is cleared only by a control write with bit 4 at 0. Writing a 1 never sets it.
- R12: Offset 4 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access valid this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_off_i | input | 3 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from offset |
| busy_o | output | 1 | Write cycle in progress |
| irq_o | output | 1 | Completion interrupt |

## Verification
Write attempts come from a vector table. Each entry varies one thing in the handshake: a clean sequence, a wrong first byte, a wrong second byte, swapped bytes, a foreign read between the bytes, write enable set in the same write as the strobe, write enable absent, or a program-space select. A read-back of the target byte tells a real write apart from a refused one, because refused attempts aim at bytes already written with different data. Directed tests then probe the timing of the next-cycle read, the register freeze during a write, the exact busy length, flag stickiness, and the rule that a second strobe needs a new handshake.

// File: rtl/nvm_ctrl_pkg.sv
package nvm_ctrl_pkg;
  localparam logic [2:0] OFF_ADDR_LO = 3'd0;
  localparam logic [2:0] OFF_ADDR_HI = 3'd1;
  localparam logic [2:0] OFF_DATA    = 3'd2;
  localparam logic [2:0] OFF_CTRL    = 3'd3;
  localparam logic [2:0] OFF_UNLOCK  = 3'd4;

  localparam int unsigned CB_RD   = 0;
  localparam int unsigned CB_WR   = 1;
  localparam int unsigned CB_WEN  = 2;
  localparam int unsigned CB_DONE = 4;
  localparam int unsigned CB_IE   = 5;
  localparam int unsigned CB_CFG  = 6;
  localparam int unsigned CB_PROG = 7;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_HALF  = 2'd1,
    UL_ARMED = 2'd2
  } unlock_state_e;
endpackage

// File: rtl/nvm_unlock_fsm.sv
module nvm_unlock_fsm
  import nvm_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       acc_i,
  input  logic       wr_i,
  input  logic       is_unlock_i,
  input  logic [7:0] wdata_i,
  input  logic       busy_i,
  output logic       armed_o
);
  unlock_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (busy_i) begin
      state_d = UL_IDLE;
    end else if (acc_i) begin
      if (!is_unlock_i) begin
        state_d = UL_IDLE; // any foreign access breaks or spends the sequence
      end else if (wr_i) begin
        unique case (state_q)
          UL_HALF: state_d = (wdata_i == KEY_SECOND) ? UL_ARMED : UL_IDLE;
          default: state_d = (wdata_i == KEY_FIRST)  ? UL_HALF  : UL_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= UL_IDLE;
    else         state_q <= state_d;
  end

  assign armed_o = (state_q == UL_ARMED);

  // R4
  armed_from_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == UL_ARMED && $past(state_q) != UL_ARMED) |-> $past(state_q) == UL_HALF);

  // R8
  idle_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_i) |-> state_q == UL_IDLE);
endmodule

// File: rtl/nvm_write_timer.sv
module nvm_write_timer #(
  parameter int unsigned CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic finish_o
);
  localparam int unsigned CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o   = busy_q;
  assign finish_o = busy_q && (cnt_q == '0);

  // R8
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);

  // R9
  busy_from_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(start_i));
endmodule

// File: rtl/nvm_byte_array.sv
module nvm_byte_array #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] cell_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) cell_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = cell_q[raddr_i];
endmodule

// File: rtl/nvm_data_ctrl.sv
module nvm_data_ctrl
  import nvm_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned WR_CYCLES = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_sel_i,
  input  logic       bus_wr_i,
  input  logic [2:0] bus_off_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  output logic       busy_o,
  output logic       irq_o
);
  localparam int unsigned HI_W = ADDR_W - 8;

  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic              wen_q, done_q, ie_q, cfg_q, prog_q;
  logic              busy, finish, armed, start;
  logic [7:0]        arr_rdata;
  logic              bus_we, ctrl_we, data_space;

  assign bus_we     = bus_sel_i && bus_wr_i && !busy;
  assign ctrl_we    = bus_we && (bus_off_i == OFF_CTRL);
  assign data_space = !bus_wdata_i[CB_PROG] && !bus_wdata_i[CB_CFG];
  // write enable is the old value: setting it in the same write does not count
  assign start      = ctrl_we && armed && bus_wdata_i[CB_WR] && wen_q && data_space;

  nvm_unlock_fsm u_unlock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (bus_sel_i),
    .wr_i        (bus_wr_i),
    .is_unlock_i (bus_off_i == OFF_UNLOCK),
    .wdata_i     (bus_wdata_i),
    .busy_i      (busy),
    .armed_o     (armed)
  );

  nvm_write_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .busy_o   (busy),
    .finish_o (finish)
  );

  nvm_byte_array #(.AW(ADDR_W), .DW(8)) u_array (
    .clk_i   (clk_i),
    .we_i    (finish),
    .waddr_i (addr_q),
    .wdata_i (data_q),
    .raddr_i (addr_q),
    .rdata_o (arr_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      wen_q  <= 1'b0;
      done_q <= 1'b0;
      ie_q   <= 1'b0;
      cfg_q  <= 1'b0;
      prog_q <= 1'b0;
    end else begin
      if (finish) done_q <= 1'b1;
      if (bus_we) begin
        unique case (bus_off_i)
          OFF_ADDR_LO: addr_q[7:0]        <= bus_wdata_i;
          OFF_ADDR_HI: addr_q[ADDR_W-1:8] <= bus_wdata_i[HI_W-1:0];
          OFF_DATA:    data_q             <= bus_wdata_i;
          OFF_CTRL: begin
            wen_q  <= bus_wdata_i[CB_WEN];
            ie_q   <= bus_wdata_i[CB_IE];
            cfg_q  <= bus_wdata_i[CB_CFG];
            prog_q <= bus_wdata_i[CB_PROG];
            if (!bus_wdata_i[CB_DONE]) done_q <= 1'b0;
            if (bus_wdata_i[CB_RD] && data_space) data_q <= arr_rdata;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (bus_off_i)
      OFF_ADDR_LO: bus_rdata_o = addr_q[7:0];
      OFF_ADDR_HI: bus_rdata_o = 8'(addr_q[ADDR_W-1:8]);
      OFF_DATA:    bus_rdata_o = data_q;
      OFF_CTRL:    bus_rdata_o = {prog_q, cfg_q, ie_q, done_q, 1'b0, wen_q, busy, 1'b0};
      default:     bus_rdata_o = 8'h00;
    endcase
  end

  assign busy_o = busy;
  assign irq_o  = done_q && ie_q;

  // R7
  wen_sw_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wen_q) |-> $past(ctrl_we));

  // R8
  frozen_regs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy) |-> ($stable(addr_q) && $stable(data_q) && $stable(wen_q)));

  // R11
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_q) |-> $past(ctrl_we));

  // R4
  start_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(armed));

  // R10
  finish_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> done_q);
endmodule

// File: tb/tb_nvm_data_ctrl.sv
`timescale 1ns/1ps
module tb_nvm_data_ctrl;
  localparam int unsigned WCYC = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr = 1'b0;
  logic [2:0] off = '0;
  logic [7:0] wdat = '0;
  logic [7:0] rdat;
  logic       busy, irq;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] model [1024];

  always #2 clk = ~clk;

  nvm_data_ctrl #(.ADDR_W(10), .WR_CYCLES(WCYC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_off_i(off), .bus_wdata_i(wdat), .bus_rdata_o(rdat),
    .busy_o(busy), .irq_o(irq)
  );

  // {kind, addr, data, expect_write}
  // kinds: 0 clean, 1 bad first key, 2 bad second key, 3 foreign read between keys,
  // 4 enable set with strobe, 5 enable clear, 6 keys swapped, 7 program space selected
  localparam logic [21:0] VEC [11] = '{
    {3'd0, 10'h005, 8'h3C, 1'b1},
    {3'd0, 10'h3FF, 8'hA5, 1'b1},
    {3'd0, 10'h100, 8'h01, 1'b1},
    {3'd1, 10'h005, 8'h77, 1'b0},
    {3'd2, 10'h005, 8'h78, 1'b0},
    {3'd3, 10'h3FF, 8'h11, 1'b0},
    {3'd4, 10'h100, 8'h22, 1'b0},
    {3'd5, 10'h100, 8'h23, 1'b0},
    {3'd6, 10'h3FF, 8'h24, 1'b0},
    {3'd7, 10'h005, 8'h25, 1'b0},
    {3'd0, 10'h005, 8'hC3, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [2:0] o, input logic [7:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; off = o; wdat = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic br(input logic [2:0] o, output logic [7:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; off = o;
    #1 d = rdat;
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic set_addr(input logic [9:0] a);
    bw(3'd0, a[7:0]);
    bw(3'd1, {6'd0, a[9:8]});
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int i = 0; i < 5; i++) begin
      br(3'(i), v);
      chk("R1 reset reg", {8'd0, v}, 16'h0000);
    end
    chk("R1 reset busy/irq", {14'd0, busy, irq}, 16'h0000);

    // R12 unlock readback
    bw(3'd4, 8'h55);
    br(3'd4, v);
    chk("R12 unlock reads zero", {8'd0, v}, 16'h0000);

    // table of write attempts
    for (int k = 0; k < 11; k++) begin
      logic [2:0] kind;
      logic [9:0] a;
      logic [7:0] d;
      logic       ex;
      {kind, a, d, ex} = VEC[k];
      bw(3'd3, 8'h00);
      set_addr(a);
      bw(3'd2, d);
      if (kind != 3'd4 && kind != 3'd5) bw(3'd3, 8'h04);
      case (kind)
        3'd1: begin bw(3'd4, 8'h54); bw(3'd4, 8'hAA); end
        3'd2: begin bw(3'd4, 8'h55); bw(3'd4, 8'hAB); end
        3'd3: begin bw(3'd4, 8'h55); br(3'd0, v); bw(3'd4, 8'hAA); end
        3'd6: begin bw(3'd4, 8'hAA); bw(3'd4, 8'h55); end
        default: begin bw(3'd4, 8'h55); bw(3'd4, 8'hAA); end
      endcase
      case (kind)
        3'd4: bw(3'd3, 8'h06);
        3'd5: bw(3'd3, 8'h02);
        3'd7: bw(3'd3, 8'h86);
        default: bw(3'd3, 8'h06);
      endcase
      if (ex) begin
        cnt = 0;
        while (busy) begin cnt++; @(negedge clk); end
        chk("R9 busy length", 16'(cnt), 16'(WCYC));
        model[a] = d;
      end else begin
        if (kind == 3'd4 || kind == 3'd5)
          chk("R6 no start without prior enable", {15'd0, busy}, 16'h0000);
        else
          chk("R4 no start on broken handshake", {15'd0, busy}, 16'h0000);
      end
      wait_idle();
      bw(3'd3, 8'h01);
      br(3'd2, v);
      if (ex) chk("R4 clean write lands", {8'd0, v}, {8'd0, model[a]});
      else if (kind == 3'd4 || kind == 3'd5) chk("R6 byte unchanged", {8'd0, v}, {8'd0, model[a]});
      else if (kind == 3'd7) chk("R2 program select blocks write", {8'd0, v}, {8'd0, model[a]});
      else chk("R4 byte unchanged", {8'd0, v}, {8'd0, model[a]});
    end

    // R2 read visible next cycle, strobe reads back 0
    set_addr(10'h3FF);
    bw(3'd3, 8'h01);
    br(3'd2, v);
    chk("R2 next-cycle read", {8'd0, v}, 16'h00A5);
    br(3'd3, v);
    chk("R2 strobe reads zero", {8'd0, v}, 16'h0000);
    set_addr(10'h005);
    bw(3'd3, 8'h81);
    br(3'd2, v);
    chk("R2 select blocks read", {8'd0, v}, 16'h00A5);

    // R3 hold behaviour
    bw(3'd2, 8'h5A);
    bw(3'd3, 8'h00);
    set_addr(10'h3FF);
    br(3'd2, v);
    chk("R3 data holds sw value", {8'd0, v}, 16'h005A);

    // R8 / R10 / R7 on a write with interrupt enabled
    set_addr(10'h100);
    bw(3'd2, 8'h66);
    bw(3'd3, 8'h24);
    bw(3'd4, 8'h55); bw(3'd4, 8'hAA);
    bw(3'd3, 8'h26);
    bw(3'd0, 8'h07);
    bw(3'd2, 8'h99);
    bw(3'd3, 8'h00);
    bw(3'd4, 8'h55);
    br(3'd3, v);
    chk("R9 strobe bit set while busy", {8'd0, v}, 16'h0026);
    wait_idle();
    @(negedge clk);
    br(3'd3, v);
    chk("R10 completion bits", {8'd0, v}, 16'h0034);
    chk("R10 irq raised", {15'd0, irq}, 16'h0001);
    chk("R7 enable kept", {15'd0, v[2]}, 16'h0001);
    br(3'd0, v);
    chk("R8 address frozen", {8'd0, v}, 16'h0000);
    br(3'd2, v);
    chk("R8 data frozen", {8'd0, v}, 16'h0066);

    // R5 second strobe without handshake
    bw(3'd3, 8'h36);
    chk("R5 no start without new handshake", {15'd0, busy}, 16'h0000);

    // R11 sticky flag
    repeat (10) @(negedge clk);
    br(3'd3, v);
    chk("R11 flag sticky", {15'd0, v[4]}, 16'h0001);
    bw(3'd3, 8'h24);
    br(3'd3, v);
    chk("R11 flag cleared by sw", {8'd0, v}, 16'h0024);
    chk("R10 irq drops", {15'd0, irq}, 16'h0000);
    bw(3'd3, 8'h34);
    br(3'd3, v);
    chk("R11 writing one does not set", {8'd0, v}, 16'h0024);

    // R9 array content after interval
    bw(3'd3, 8'h01);
    br(3'd2, v);
    chk("R9 array updated", {8'd0, v}, 16'h0066);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule